// File: doc/BRIEF.md
# LFSR-Addressed Pixel Scrambling Store

This block is one lane of a concurrent image cipher. In encrypt mode it takes a stream of pixels, each paired with a diffusion key word. It stores `pixel XOR key` into an on-chip memory at write addresses produced by a maximal-length Galois LFSR started from a per-lane seed. Once every location holds a word, it streams the memory out in ascending address order. The scattered placement is the confusion step.

Decrypt mode undoes this. Ciphertext words are stored at sequential addresses. During readout, the lane walks the same LFSR address sequence from the same seed, and XORs each word with the key word presented on that readout cycle. The plaintext then comes out in its original order.

Several lanes are instantiated side by side, one per image quadrant, each with its own seed. With `ADDR_W = 14` a lane holds a 128×128 block of 16-bit pixels; use `TAPS = 14'h3802` for x^14+x^13+x^12+x^2+1. The default build uses a 1024-entry memory.

Top module: `pix_scramble_lane`

## Requirements
- R1: In encrypt mode, the word stored for accepted pixel k is `in_pix XOR in_key` of that same beat.
- R2: The address sequence for k = 0 .. DEPTH-1 is: k = 0 uses the seed; each following k uses the next LFSR state, where the next state of s is `s>>1` when s[0] = 0 and `(s>>1) XOR TAPS` when s[0] = 1; k = DEPTH-1 uses address 0. Every location is written exactly once. In encrypt mode this is the write order, in decrypt mode the read order.
- R3: A seed of all zeros is replaced by `SEED_DFLT` (default 1).
- R4: In encrypt mode, readout delivers all DEPTH words in ascending address order, one per cycle with no gaps. The first `out_valid` comes the cycle after `write_done`, and `out_valid` is never high while the lane is filling.
- R5: In decrypt mode, `in_pix` is stored at address k for beat k. During readout, each cycle with `in_valid` high takes `in_key` and yields the word at the next R2 address XORed with that key, one cycle later. Cycles without `in_valid` yield nothing.
- R6: `in_ready` is high while filling and low during readout. Pixels offered during readout are not stored.
- R7: `write_done` is a one-cycle pulse in the cycle after the DEPTH-th accepted pixel; `in_ready` is low in that cycle.
- R8: `read_done` is high together with the last `out_valid` of a block, and `in_ready` is high again in that same cycle.
- R9: `in_seed` and `in_dec` are sampled only on the first accepted beat of a block; later changes during that block have no effect.
- R10: After reset, `in_ready` is 1 and `out_valid`, `write_done` and `read_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel beat while filling; key beat during decrypt readout |
| in_ready | output | 1 | Lane accepts pixels (fill phase) |
| in_pix | input | PIX_W | Plaintext (encrypt) or ciphertext (decrypt) word |
| in_key | input | PIX_W | Diffusion key word |
| in_seed | input | ADDR_W | LFSR seed for this block |
| in_dec | input | 1 | 1 = decrypt, 0 = encrypt |
| out_valid | output | 1 | Output word valid |
| out_data | output | PIX_W | Ciphertext or recovered plaintext |
| write_done | output | 1 | Block fully stored (pulse) |
| read_done | output | 1 | Last output word of block (pulse) |

## Verification
The embedded assertions check the following on every cycle:
- the LFSR never reaches the all-zero state;
- the done flags are single pulses;
- `read_done` lines up with the final output and the reopening of the input;
- no output appears during a fill.

Only the bench scenarios can show that data is placed correctly. They cover the exact scatter order, zero-seed substitution, and an encrypt-then-decrypt round trip that recovers the plaintext. They also show that pixels offered during readout and seed or mode changes in mid-block leave the result untouched.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic {PH_FILL = 1'b0, PH_DRAIN = 1'b1} phase_t;
endpackage

// File: rtl/scr_addr_gen.sv
module scr_addr_gen #(
  parameter int              W         = 10,
  parameter logic [W-1:0]    TAPS      = 10'h240,
  parameter logic [W-1:0]    SEED_DFLT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         first,
  input  logic         last,
  input  logic         step,
  input  logic [W-1:0] seed_in,
  output logic [W-1:0] addr
);
  logic [W-1:0] state_q;
  logic [W-1:0] seed_ok;
  logic [W-1:0] base;

  function automatic logic [W-1:0] adv(input logic [W-1:0] s);
    adv = s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
  endfunction

  assign seed_ok = (seed_in == '0) ? SEED_DFLT : seed_in;
  assign base    = first ? seed_ok : state_q;
  // zero is inserted once, at the final slot of the walk
  assign addr    = first ? seed_ok : (last ? '0 : state_q);

  always_ff @(posedge clk) begin
    if (rst)       state_q <= SEED_DFLT;
    else if (step) state_q <= adv(base);
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state_q != '0); // R2
endmodule

// File: rtl/scr_ram.sv
module scr_ram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pix_scramble_lane.sv
module pix_scramble_lane #(
  parameter int                 PIX_W     = 16,
  parameter int                 ADDR_W    = 10,
  parameter logic [ADDR_W-1:0]  TAPS      = 10'h240,
  parameter logic [ADDR_W-1:0]  SEED_DFLT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic [PIX_W-1:0]  in_key,
  input  logic [ADDR_W-1:0] in_seed,
  input  logic              in_dec,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_data,
  output logic              write_done,
  output logic              read_done
);
  import scr_pkg::*;

  phase_t              phase_q;
  logic [ADDR_W-1:0]   cnt_q;
  logic                dec_q;
  logic [ADDR_W-1:0]   seed_q;
  logic [PIX_W-1:0]    key_q;
  logic [PIX_W-1:0]    ram_q;

  logic                filling, first, last;
  logic                wr_fire, rd_fire, dec_eff, gen_step;
  logic [ADDR_W-1:0]   seed_eff, gen_addr, waddr, raddr;
  logic [PIX_W-1:0]    wdata;

  assign filling  = (phase_q == PH_FILL);
  assign in_ready = filling;
  assign first    = (cnt_q == '0);
  assign last     = &cnt_q;

  assign wr_fire  = filling && in_valid;
  assign rd_fire  = !filling && (!dec_q || in_valid);
  assign dec_eff  = (filling && first) ? in_dec  : dec_q;
  assign seed_eff = (filling && first) ? in_seed : seed_q;
  assign gen_step = (wr_fire && !dec_eff) || (rd_fire && dec_q);

  assign waddr = dec_eff ? cnt_q : gen_addr;
  assign wdata = dec_eff ? in_pix : (in_pix ^ in_key);
  assign raddr = dec_q ? gen_addr : cnt_q;

  scr_addr_gen #(.W(ADDR_W), .TAPS(TAPS), .SEED_DFLT(SEED_DFLT)) u_gen (
    .clk(clk), .rst(rst), .first(first), .last(last), .step(gen_step),
    .seed_in(seed_eff), .addr(gen_addr)
  );

  scr_ram #(.AW(ADDR_W), .DW(PIX_W)) u_ram (
    .clk(clk), .we(wr_fire), .waddr(waddr), .wdata(wdata),
    .re(rd_fire), .raddr(raddr), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_FILL;
      cnt_q      <= '0;
      dec_q      <= 1'b0;
      seed_q     <= SEED_DFLT;
      key_q      <= '0;
      out_valid  <= 1'b0;
      write_done <= 1'b0;
      read_done  <= 1'b0;
    end else begin
      write_done <= 1'b0;
      read_done  <= 1'b0;
      out_valid  <= rd_fire;
      if (wr_fire) begin
        if (first) begin
          dec_q  <= in_dec;
          seed_q <= in_seed;
        end
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          phase_q    <= PH_DRAIN;
          write_done <= 1'b1;
        end
      end
      if (rd_fire) begin
        cnt_q <= cnt_q + 1'b1;
        key_q <= dec_q ? in_key : '0;
        if (last) begin
          phase_q   <= PH_FILL;
          read_done <= 1'b1;
        end
      end
    end
  end

  assign out_data = ram_q ^ key_q;

  AST_WDONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    write_done |=> !write_done); // R7
  AST_WDONE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    write_done |-> !in_ready); // R6
  AST_RDONE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    read_done |-> (out_valid && in_ready)); // R8
  AST_QUIET_FILL: assert property (@(posedge clk) disable iff (rst)
    (in_ready && $past(in_ready)) |-> !out_valid); // R4
endmodule

// File: tb/sim_pix_scramble_lane.sv
`timescale 1ns/1ps
module sim_pix_scramble_lane;
  localparam int PW = 16;
  localparam int AW = 8;
  localparam int D  = 1 << AW;
  localparam logic [AW-1:0] TP = 8'hB8;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_dec = 1'b0;
  logic in_ready, out_valid, write_done, read_done;
  logic [PW-1:0] in_pix = '0, in_key = '0, out_data;
  logic [AW-1:0] in_seed = '0;

  always #2.5 clk = ~clk;

  pix_scramble_lane #(.PIX_W(PW), .ADDR_W(AW), .TAPS(TP), .SEED_DFLT(8'd1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_key(in_key), .in_seed(in_seed), .in_dec(in_dec),
    .out_valid(out_valid), .out_data(out_data),
    .write_done(write_done), .read_done(read_done));

  int n_chk = 0, n_bad = 0;
  logic [PW-1:0] din [D];
  logic [PW-1:0] kin [D];
  logic [PW-1:0] pt  [D];
  logic [PW-1:0] ct  [D];
  logic [PW-1:0] got [D];
  logic [PW-1:0] expv[D];
  logic [AW-1:0] seq [D];
  int got_n = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] s);
    nxt = s[0] ? ((s >> 1) ^ TP) : (s >> 1);
  endfunction

  task automatic make_seq(input logic [AW-1:0] seed);
    logic [AW-1:0] s;
    s = (seed == '0) ? 8'd1 : seed;   // R3 default
    for (int k = 0; k < D - 1; k++) begin
      seq[k] = s;
      s = nxt(s);
    end
    seq[D-1] = '0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid && got_n < D) begin
      got[got_n] = out_data;
      chk(read_done == (got_n == D - 1), "R8 read_done position", read_done, got_n == D - 1);
      if (got_n == D - 1) chk(in_ready, "R8 in_ready reopens", in_ready, 1);
      got_n++;
    end
  end

  task automatic run_block(input bit dec, input logic [AW-1:0] seed, input int gap);
    int k;
    got_n = 0;
    k = 0;
    while (k < D) begin
      @(negedge clk);
      chk(in_ready && !out_valid, "R6 R4 ready and quiet during fill", {in_ready, out_valid}, 2'b10);
      in_valid = (($urandom % 100) >= gap);
      in_pix   = din[k];
      in_key   = kin[k];
      in_seed  = (k == 0) ? seed : AW'($urandom);   // R9 mid-block changes
      in_dec   = (k == 0) ? dec : ~dec;
      if (in_valid) k++;
    end
    @(negedge clk);
    chk(write_done, "R7 write_done pulse", write_done, 1);
    chk(!in_ready, "R6 in_ready low in readout", in_ready, 0);
    if (!dec) begin
      for (int i = 0; i < D - 2; i++) begin
        in_valid = $urandom;                          // R6 ignored offers
        in_pix   = PW'($urandom);
        @(negedge clk);
        if (i == 0) chk(!write_done, "R7 write_done single cycle", write_done, 0);
        if (i < D - 3) chk(!in_ready, "R6 in_ready low in readout", in_ready, 0);
      end
      in_valid = 1'b0;
    end else begin
      k = 0;
      while (k < D) begin
        in_valid = (($urandom % 100) >= gap);
        in_key   = kin[k];
        in_pix   = PW'($urandom);
        if (in_valid) k++;
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
    while (got_n < D) @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic compare(input string req);
    for (int j = 0; j < D; j++)
      chk(got[j] == expv[j], req, got[j], expv[j]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !out_valid && !write_done && !read_done, "R10 reset state",
        {in_ready, out_valid, write_done, read_done}, 4'b1000);

    // A: random encrypt with gaps
    for (int k = 0; k < D; k++) begin pt[k] = PW'($urandom); kin[k] = PW'($urandom); din[k] = pt[k]; end
    make_seq(8'h5A);
    for (int k = 0; k < D; k++) expv[seq[k]] = pt[k] ^ kin[k];
    run_block(1'b0, 8'h5A, 30);
    compare("R1 R2 R4 R9 encrypt word");
    for (int j = 0; j < D; j++) ct[j] = got[j];

    // B: decrypt the ciphertext back
    for (int j = 0; j < D; j++) din[j] = ct[j];
    for (int k = 0; k < D; k++) expv[k] = pt[k];
    run_block(1'b1, 8'h5A, 40);
    compare("R5 R9 decrypt round trip word");

    // C: zero seed, index pixels, zero key
    for (int k = 0; k < D; k++) begin din[k] = PW'(k); kin[k] = '0; end
    make_seq(8'h00);
    for (int k = 0; k < D; k++) expv[seq[k]] = PW'(k);
    run_block(1'b0, 8'h00, 0);
    compare("R3 R2 zero seed placement");

    // D: all-ones pixels against patterned key, seed 0xFF
    for (int k = 0; k < D; k++) begin din[k] = 16'hFFFF; kin[k] = (k % 2) ? 16'hAAAA : 16'h5555; end
    make_seq(8'hFF);
    for (int k = 0; k < D; k++) expv[seq[k]] = 16'hFFFF ^ kin[k];
    run_block(1'b0, 8'hFF, 10);
    compare("R1 R4 patterned encrypt word");

    // E: decrypt with zero seed on random data
    for (int j = 0; j < D; j++) begin din[j] = PW'($urandom); kin[j] = PW'($urandom); end
    make_seq(8'h00);
    for (int k = 0; k < D; k++) expv[k] = din[seq[k]] ^ kin[k];
    run_block(1'b1, 8'h00, 20);
    compare("R5 R3 decrypt read order word");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule